// File: doc/BRIEF.md
# Three-Way Intersection Signal Sequencer

This block sequences the lamps at a junction of three streets: a busy north-south main street, an east-west cross street, and a side street that is served only when its vehicle detector reports a waiting car. Southbound main-street traffic gets a protected left-turn arrow at the start of every cycle. While the arrow is lit, straight-ahead southbound traffic keeps its green, and every other approach is held at red.

One cycle runs turn-arrow green, turn-arrow yellow, main green (both main directions), main yellow, cross green, cross yellow, and then the side-street green and yellow if a car is waiting. After that it returns to the turn arrow. Phase lengths come from an internal down-counter. The counter reloads on every phase entry and reports a short and a long expiry, both parameters given in clock cycles. The side-street green ends as soon as the detector drops, and it never lasts longer than the long interval. All lamp outputs are registered, so the lamps follow the phase register by one clock.

Top module: `tri_xing_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every approach shows red and both arrow drives are low from that edge on. After release, the all-red pattern stays for exactly SHORT_CYC clocks before the arrow phase starts.
- R2: Each approach lamp bus is one-hot at every clock: bit 2 is green, bit 1 is yellow and bit 0 is red.
- R3: Phases follow this fixed order: arrow green, arrow yellow, main green, main yellow, cross green, cross yellow, then optionally side green and side yellow, then arrow green again.
- R4: During both arrow phases the southbound lamp is green. The northbound, cross and side lamps are red. Exactly one of `turn_grn` or `turn_yel` is high, and neither arrow drive is high in any other phase.
- R5: Arrow green, arrow yellow, main yellow, cross yellow and side yellow each last exactly SHORT_CYC clocks.
- R6: Main green and cross green each last exactly LONG_CYC clocks.
- R7: If `car_wait` is low in the last clock of cross yellow, the side phase is skipped and arrow green follows directly.
- R8: In side green, a clock in which `car_wait` is low ends the green, and side yellow appears at the outputs one clock later.
- R9: Side green never lasts more than LONG_CYC clocks, even with `car_wait` held high.
- R10: A cross green or side green is never shown together with any other green on a different street.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_wait | input | 1 | Side-street vehicle detector, high while a car is waiting |
| sb_lamp | output | 3 | Southbound main lamps {green, yellow, red} |
| nb_lamp | output | 3 | Northbound main lamps {green, yellow, red} |
| ew_lamp | output | 3 | Cross-street lamps {green, yellow, red} |
| side_lamp | output | 3 | Side-street lamps {green, yellow, red} |
| turn_grn | output | 1 | Southbound left-turn arrow, green |
| turn_yel | output | 1 | Southbound left-turn arrow, yellow |

## Verification
A wrong phase register shows within one clock as a lamp pattern that does not belong to the expected phase, or as a phase appearing out of order. A wrong interval counter shows as a phase whose visible dwell is one or more clocks off from SHORT_CYC or LONG_CYC. The bench therefore measures the dwell of each lamp pattern clock by clock as it walks the cycle. Detector faults show up in a single cycle as a side phase that should have been skipped, a gap-out that arrives late, or a side green that is not capped.

// File: rtl/xing_pkg.sv
package xing_pkg;

  typedef enum logic [3:0] {
    PH_ALL_RED,
    PH_ARROW_G,
    PH_ARROW_Y,
    PH_MAIN_G,
    PH_MAIN_Y,
    PH_CROSS_G,
    PH_CROSS_Y,
    PH_SIDE_G,
    PH_SIDE_Y
  } phase_t;

  typedef enum logic [1:0] {
    C_RED,
    C_YEL,
    C_GRN
  } color_t;

  localparam int N_APPR  = 4;
  localparam int AP_SB   = 0;
  localparam int AP_NB   = 1;
  localparam int AP_EW   = 2;
  localparam int AP_SIDE = 3;

  localparam logic [2:0] LAMP_R = 3'b001;
  localparam logic [2:0] LAMP_Y = 3'b010;
  localparam logic [2:0] LAMP_G = 3'b100;

  // Colour each approach shows in a given phase.
  function automatic color_t approach_color(input phase_t p, input int a);
    color_t c;
    c = C_RED;
    unique case (p)
      PH_ARROW_G, PH_ARROW_Y: if (a == AP_SB) c = C_GRN;
      PH_MAIN_G:  if (a == AP_SB || a == AP_NB) c = C_GRN;
      PH_MAIN_Y:  if (a == AP_SB || a == AP_NB) c = C_YEL;
      PH_CROSS_G: if (a == AP_EW) c = C_GRN;
      PH_CROSS_Y: if (a == AP_EW) c = C_YEL;
      PH_SIDE_G:  if (a == AP_SIDE) c = C_GRN;
      PH_SIDE_Y:  if (a == AP_SIDE) c = C_YEL;
      default:    c = C_RED;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/xing_interval_timer.sv
module xing_interval_timer #(
  parameter int LONG_CYC  = 20,
  parameter int SHORT_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic short_exp,
  output logic long_exp
);
  localparam int TW = $clog2(LONG_CYC + 1);
  localparam logic [TW-1:0] LOAD_VAL   = TW'(LONG_CYC - 1);
  localparam logic [TW-1:0] SHORT_MARK = TW'(LONG_CYC - SHORT_CYC);

  logic [TW-1:0] cnt;

  // Down-counter: reloaded on phase entry, parks at zero.
  always_ff @(posedge clk) begin
    if (rst || start)
      cnt <= LOAD_VAL;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign short_exp = (cnt <= SHORT_MARK);
  assign long_exp  = (cnt == '0);

  // R6: a fresh start never reports the long expiry on the next clock
  assert_fresh_start_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> !long_exp);

endmodule

// File: rtl/xing_phase_seq.sv
module xing_phase_seq
  import xing_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   car_wait,
  input  logic   short_exp,
  input  logic   long_exp,
  output phase_t phase,
  output logic   start
);
  phase_t cur, nxt;
  logic   leave;

  always_comb begin
    nxt   = cur;
    leave = 1'b0;
    unique case (cur)
      PH_ALL_RED: begin leave = short_exp; nxt = PH_ARROW_G; end
      PH_ARROW_G: begin leave = short_exp; nxt = PH_ARROW_Y; end
      PH_ARROW_Y: begin leave = short_exp; nxt = PH_MAIN_G;  end
      PH_MAIN_G:  begin leave = long_exp;  nxt = PH_MAIN_Y;  end
      PH_MAIN_Y:  begin leave = short_exp; nxt = PH_CROSS_G; end
      PH_CROSS_G: begin leave = long_exp;  nxt = PH_CROSS_Y; end
      PH_CROSS_Y: begin
        leave = short_exp;
        nxt   = car_wait ? PH_SIDE_G : PH_ARROW_G;
      end
      PH_SIDE_G:  begin leave = long_exp || !car_wait; nxt = PH_SIDE_Y; end
      PH_SIDE_Y:  begin leave = short_exp; nxt = PH_ARROW_G; end
      default:    begin leave = 1'b1; nxt = PH_ALL_RED; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      cur <= PH_ALL_RED;
    else if (leave)
      cur <= nxt;
  end

  assign phase = cur;
  assign start = leave;

  // R5: a yellow phase holds until the short expiry
  assert_yellow_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cur == PH_MAIN_Y && !short_exp) |=> cur == PH_MAIN_Y);
  // R7: no demand at the end of cross yellow skips the side phase
  assert_side_skip_R7: assert property (@(posedge clk) disable iff (rst)
    (cur == PH_CROSS_Y && short_exp && !car_wait) |=> cur == PH_ARROW_G);
  // R8: demand lost in side green ends it at once
  assert_gap_out_R8: assert property (@(posedge clk) disable iff (rst)
    (cur == PH_SIDE_G && !car_wait) |=> cur == PH_SIDE_Y);
  // R9: side green is capped by the long expiry
  assert_side_cap_R9: assert property (@(posedge clk) disable iff (rst)
    (cur == PH_SIDE_G && long_exp) |=> cur == PH_SIDE_Y);
  // R3: main green is only entered from arrow yellow
  assert_order_R3: assert property (@(posedge clk) disable iff (rst)
    (cur == PH_MAIN_G && $past(cur) != PH_MAIN_G) |-> $past(cur) == PH_ARROW_Y);

endmodule

// File: rtl/xing_lamp_drive.sv
module xing_lamp_drive
  import xing_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  phase_t                 phase,
  output logic [N_APPR-1:0][2:0] lamp_q,
  output logic                   arrow_g_q,
  output logic                   arrow_y_q
);

  for (genvar a = 0; a < N_APPR; a++) begin : g_appr
    color_t     col;
    logic [2:0] q;

    assign col = approach_color(phase, a);

    always_ff @(posedge clk) begin
      if (rst)
        q <= LAMP_R;
      else begin
        unique case (col)
          C_GRN:   q <= LAMP_G;
          C_YEL:   q <= LAMP_Y;
          default: q <= LAMP_R;
        endcase
      end
    end

    assign lamp_q[a] = q;

    // R2: one lamp per approach at every clock
    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot(q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arrow_g_q <= 1'b0;
      arrow_y_q <= 1'b0;
    end else begin
      arrow_g_q <= (phase == PH_ARROW_G);
      arrow_y_q <= (phase == PH_ARROW_Y);
    end
  end

  // R10: cross green excludes every other street's green
  assert_cross_excl_R10: assert property (@(posedge clk) disable iff (rst)
    lamp_q[AP_EW][2] |-> !(lamp_q[AP_SB][2] || lamp_q[AP_NB][2] || lamp_q[AP_SIDE][2]));
  // R10: side green excludes every other green
  assert_side_excl_R10: assert property (@(posedge clk) disable iff (rst)
    lamp_q[AP_SIDE][2] |-> !(lamp_q[AP_SB][2] || lamp_q[AP_NB][2] || lamp_q[AP_EW][2]));
  // R4: a lit arrow keeps southbound green and everything else red
  assert_arrow_guard_R4: assert property (@(posedge clk) disable iff (rst)
    (arrow_g_q || arrow_y_q) |-> (lamp_q[AP_SB] == LAMP_G && lamp_q[AP_NB] == LAMP_R &&
                                  lamp_q[AP_EW] == LAMP_R && lamp_q[AP_SIDE] == LAMP_R));
  // R4: the two arrow drives are never lit together
  assert_arrow_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arrow_g_q, arrow_y_q}));

endmodule

// File: rtl/tri_xing_ctrl.sv
module tri_xing_ctrl #(
  parameter int LONG_CYC  = 20,
  parameter int SHORT_CYC = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_wait,
  output logic [2:0] sb_lamp,
  output logic [2:0] nb_lamp,
  output logic [2:0] ew_lamp,
  output logic [2:0] side_lamp,
  output logic       turn_grn,
  output logic       turn_yel
);
  import xing_pkg::*;

  logic   short_exp, long_exp, start;
  phase_t phase;
  logic [N_APPR-1:0][2:0] lamps;

  xing_interval_timer #(
    .LONG_CYC (LONG_CYC),
    .SHORT_CYC(SHORT_CYC)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .short_exp(short_exp),
    .long_exp (long_exp)
  );

  xing_phase_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .car_wait (car_wait),
    .short_exp(short_exp),
    .long_exp (long_exp),
    .phase    (phase),
    .start    (start)
  );

  xing_lamp_drive u_lamps (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .lamp_q   (lamps),
    .arrow_g_q(turn_grn),
    .arrow_y_q(turn_yel)
  );

  assign sb_lamp   = lamps[AP_SB];
  assign nb_lamp   = lamps[AP_NB];
  assign ew_lamp   = lamps[AP_EW];
  assign side_lamp = lamps[AP_SIDE];

endmodule

// File: tb/tri_xing_ctrl_bench.sv
module tri_xing_ctrl_bench;
  localparam int LONG  = 8;
  localparam int SHORT = 3;

  localparam logic [2:0] R = 3'b001, Y = 3'b010, G = 3'b100;
  // pattern = {sb, nb, ew, side, turn_grn, turn_yel}
  localparam logic [13:0] P_AR = {R, R, R, R, 1'b0, 1'b0};
  localparam logic [13:0] P_TG = {G, R, R, R, 1'b1, 1'b0};
  localparam logic [13:0] P_TY = {G, R, R, R, 1'b0, 1'b1};
  localparam logic [13:0] P_MG = {G, G, R, R, 1'b0, 1'b0};
  localparam logic [13:0] P_MY = {Y, Y, R, R, 1'b0, 1'b0};
  localparam logic [13:0] P_CG = {R, R, G, R, 1'b0, 1'b0};
  localparam logic [13:0] P_CY = {R, R, Y, R, 1'b0, 1'b0};
  localparam logic [13:0] P_SG = {R, R, R, G, 1'b0, 1'b0};
  localparam logic [13:0] P_SY = {R, R, R, Y, 1'b0, 1'b0};

  // vector = {car_wait, expected pattern, expected dwell in clocks}
  localparam int NV = 23;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, P_TG, 8'(SHORT)},  // R4 R5 arrow green
    {1'b0, P_TY, 8'(SHORT)},  // R4 R5 arrow yellow
    {1'b0, P_MG, 8'(LONG)},   // R6 main green
    {1'b0, P_MY, 8'(SHORT)},  // R5 main yellow
    {1'b0, P_CG, 8'(LONG)},   // R6 cross green
    {1'b0, P_CY, 8'(SHORT)},  // R5 cross yellow, no demand
    {1'b0, P_TG, 8'(SHORT)},  // R7 side skipped
    {1'b0, P_TY, 8'(SHORT)},  // R3
    {1'b0, P_MG, 8'(LONG)},   // R3
    {1'b0, P_MY, 8'(SHORT)},  // R3
    {1'b0, P_CG, 8'(LONG)},   // R10
    {1'b1, P_CY, 8'(SHORT)},  // R3 demand raised
    {1'b1, P_SG, 8'(LONG)},   // R9 capped side green
    {1'b1, P_SY, 8'(SHORT)},  // R5 side yellow
    {1'b0, P_TG, 8'(SHORT)},  // R3 back to arrow
    {1'b0, P_TY, 8'(SHORT)},  // R4
    {1'b0, P_MG, 8'(LONG)},   // R6
    {1'b0, P_MY, 8'(SHORT)},  // R5
    {1'b0, P_CG, 8'(LONG)},   // R6
    {1'b1, P_CY, 8'(SHORT)},  // R3 demand raised
    {1'b0, P_SG, 8'd2},       // R8 gap-out
    {1'b0, P_SY, 8'(SHORT)},  // R8 yellow follows
    {1'b0, P_TG, 8'(SHORT)}   // R3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car_wait = 1'b0;
  logic [2:0] sb_lamp, nb_lamp, ew_lamp, side_lamp;
  logic turn_grn, turn_yel;
  logic [13:0] obs;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tri_xing_ctrl #(.LONG_CYC(LONG), .SHORT_CYC(SHORT)) u_tri_xing_ctrl (
    .clk(clk), .rst(rst), .car_wait(car_wait),
    .sb_lamp(sb_lamp), .nb_lamp(nb_lamp), .ew_lamp(ew_lamp), .side_lamp(side_lamp),
    .turn_grn(turn_grn), .turn_yel(turn_yel)
  );

  assign obs = {sb_lamp, nb_lamp, ew_lamp, side_lamp, turn_grn, turn_yel};

  task automatic check_pat(input logic [13:0] exp, input string req);
    checks++;
    if (obs !== exp) begin
      fails++;
      $display("FAIL %s pattern actual=%b expected=%b", req, obs, exp);
    end
  endtask

  // Count consecutive negedge samples matching pat; leaves at the next pattern.
  task automatic measure(input logic [13:0] pat, input int dwell, input string req);
    int n = 0;
    while (obs === pat && n < 200) begin
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != dwell) begin
      fails++;
      $display("FAIL %s dwell of %b actual=%0d expected=%0d", req, pat, n, dwell);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_pat(P_AR, "R1");                 // R1 reset state
    rst = 1'b0;
    @(negedge clk);
    measure(P_AR, SHORT, "R1");            // R1 all-red after release

    for (int i = 0; i < NV; i++) begin
      car_wait = VEC[i][22];
      measure(VEC[i][21:8], int'(VEC[i][7:0]), $sformatf("R3 vector %0d", i));
    end

    // R1: reset in the middle of main green
    measure(P_TY, SHORT, "R4");
    check_pat(P_MG, "R6");
    rst = 1'b1;
    @(negedge clk);
    check_pat(P_AR, "R1");
    rst = 1'b0;
    @(negedge clk);
    measure(P_AR, SHORT, "R1");
    measure(P_TG, SHORT, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule